// File: doc/BRIEF.md
# Scan Pattern Adapter and Response Corrector

This unit sits between a tester's serial stream and a scan chain whose cells pass data along their inverted output. Such a chain flips bits as they shift. The stimulus the tester wants applied, and the responses it reads back, therefore differ from the raw serial bits at some positions. The unit works on one bit per accepted input. It tracks the cell position of each bit, counting from 1 to the chain length, and flips the bit when that position needs it. The bit then leaves through a registered serial output.

A start pulse begins each pass. It also latches the direction: load for stimulus on its way into the chain, or unload for responses coming out. In load direction, odd positions are flipped and even positions pass unchanged, whatever the chain length. In unload direction the flipped positions depend on the parity of the chain length, which is fixed at elaboration. After the last position, the unit raises a done flag and ignores input until the next start.

Top module: `scan_polarity_fixer`

## Requirements
- R1: After reset, outValid and done are 0, and input bits offered before the first start pulse produce no output.
- R2: A start pulse clears done, sets the next position to 1, and latches the direction from unloadMode (0 = load, 1 = unload).
- R3: In load direction, the bit at an odd position leaves inverted and the bit at an even position leaves unchanged, for both odd and even chain lengths.
- R4: In unload direction with an odd chain length, odd positions leave inverted and even positions leave unchanged.
- R5: In unload direction with an even chain length, even positions leave inverted and odd positions leave unchanged.
- R6: Each accepted bit appears on outBit with outValid high exactly one clock after it was offered. Cycles with inValid low produce no outValid and do not advance the position.
- R7: done rises on the same clock edge on which the last position's output appears. After that, valid input is ignored and no output appears until the next start pulse.
- R8: A bit offered in the same cycle as a start pulse is discarded.
- R9: A change of unloadMode during a pass has no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begins a pass and latches the direction |
| unloadMode | input | 1 | Direction select: 0 = load, 1 = unload |
| inBit | input | 1 | Serial input bit |
| inValid | input | 1 | inBit is offered this cycle |
| outBit | output | 1 | Registered, polarity-corrected bit |
| outValid | output | 1 | outBit holds a new bit |
| done | output | 1 | All positions of the pass have been handled |

## Verification
Every output result is due one clock after its input bit is taken. The bench drives inputs on the falling edge. It reads outBit, outValid and done at the next falling edge, half a period after the rising edge that registered them. Gap cycles, overrun attempts and start collisions are each checked at that same falling edge for the absence of outValid. done is checked in the cycle that carries the final output. Two instances cover the two chain-length parities. A round trip through a model of an inverting chain confirms that corrected responses equal the captured values.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic {
    DIR_LOAD   = 1'b0,
    DIR_UNLOAD = 1'b1
  } dir_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic take;       // an input bit is accepted this cycle
    logic oddPos;     // current position is odd
    logic unloadDir;  // pass runs in unload direction
  } ctrlStrb_t;

endpackage

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int CHAIN_LEN = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      unloadMode,
  input  logic      inValid,
  output ctrlStrb_t strb,
  output logic      done
);

  localparam int CW = $clog2(CHAIN_LEN + 1);
  localparam logic [CW-1:0] LAST_POS  = CW'(CHAIN_LEN);
  localparam logic [CW-1:0] FIRST_POS = CW'(1);

  logic [CW-1:0] pos;
  logic          armed;
  dir_e          dirQ;
  logic          takeNow;

  assign takeNow = armed && inValid && !startPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos   <= FIRST_POS;
      armed <= 1'b0;
      done  <= 1'b0;
      dirQ  <= DIR_LOAD;
    end else if (startPulse) begin
      pos   <= FIRST_POS;
      armed <= 1'b1;
      done  <= 1'b0;
      dirQ  <= unloadMode ? DIR_UNLOAD : DIR_LOAD;
    end else if (takeNow) begin
      if (pos == LAST_POS) begin
        armed <= 1'b0;
        done  <= 1'b1;
      end else begin
        pos <= pos + FIRST_POS;
      end
    end
  end

  always_comb begin
    strb.take      = takeNow;
    strb.oddPos    = pos[0];
    strb.unloadDir = (dirQ == DIR_UNLOAD);
  end

endmodule

// File: rtl/spf_dp.sv
module spf_dp
  import spf_pkg::*;
#(
  parameter int CHAIN_LEN = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  input  logic      inBit,
  output logic      outBit,
  output logic      outValid
);

  localparam bit EVEN_LEN = (CHAIN_LEN % 2) == 0;

  logic unloadFlip;
  logic flipNow;

  generate
    if (EVEN_LEN) begin : g_evenLen
      assign unloadFlip = ~strb.oddPos;
    end else begin : g_oddLen
      assign unloadFlip = strb.oddPos;
    end
  endgenerate

  assign flipNow = strb.unloadDir ? unloadFlip : strb.oddPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.take;
      if (strb.take) outBit <= inBit ^ flipNow;
    end
  end

endmodule

// File: rtl/scan_polarity_fixer.sv
module scan_polarity_fixer
  import spf_pkg::*;
#(
  parameter int CHAIN_LEN = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic startPulse,
  input  logic unloadMode,
  input  logic inBit,
  input  logic inValid,
  output logic outBit,
  output logic outValid,
  output logic done
);

  ctrlStrb_t strbW;

  spf_ctrl #(.CHAIN_LEN(CHAIN_LEN)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .unloadMode (unloadMode),
    .inValid    (inValid),
    .strb       (strbW),
    .done       (done)
  );

  spf_dp #(.CHAIN_LEN(CHAIN_LEN)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strbW),
    .inBit    (inBit),
    .outBit   (outBit),
    .outValid (outValid)
  );

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int CHAIN_LEN = 7
) (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic take,
  input logic outValid,
  input logic done
);

  localparam int KW = $clog2(CHAIN_LEN + 2) + 1;

  logic [KW-1:0] outCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outCount <= '0;
    else if (startPulse) outCount <= '0;
    else if (outValid) outCount <= outCount + KW'(1);
  end

  assert_take_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    take |=> outValid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    !take |=> !outValid);

  assert_done_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> !outValid);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (!done && !outValid));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    outCount <= KW'(CHAIN_LEN));

endmodule

bind scan_polarity_fixer spf_checker #(.CHAIN_LEN(CHAIN_LEN)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .take       (strbW.take),
  .outValid   (outValid),
  .done       (done)
);

// File: tb/sim_scan_polarity_fixer.sv
`timescale 1ns/1ps
module sim_scan_polarity_fixer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] startP = '0;
  logic [1:0] modeIn = '0;
  logic [1:0] inB = '0;
  logic [1:0] inV = '0;
  logic [1:0] outB, outV, doneW;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  scan_polarity_fixer #(.CHAIN_LEN(7)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startP[0]), .unloadMode(modeIn[0]),
    .inBit(inB[0]), .inValid(inV[0]), .outBit(outB[0]), .outValid(outV[0]),
    .done(doneW[0]));

  scan_polarity_fixer #(.CHAIN_LEN(6)) u1 (
    .clk(clk), .rstN(rstN), .startPulse(startP[1]), .unloadMode(modeIn[1]),
    .inBit(inB[1]), .inValid(inV[1]), .outBit(outB[1]), .outValid(outV[1]),
    .done(doneW[1]));

  function automatic int lenOf(int u);
    return (u == 0) ? 7 : 6;
  endfunction

  // polarity rule taken from the requirements
  function automatic bit flipAt(int pos, bit unl, int n);
    if (!unl) return (pos % 2) == 1;
    if (n % 2) return (pos % 2) == 1;
    return (pos % 2) == 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doStart(int u, bit unl);
    @(negedge clk);
    startP[u] = 1'b1;
    modeIn[u] = unl;
    @(negedge clk);
    startP[u] = 1'b0;
    check(doneW[u] == 1'b0, "R2 done cleared", doneW[u], 0);
    check(outV[u] == 1'b0, "R2 no output after start", outV[u], 0);
  endtask

  // one full pass; expected values computed from the position rule
  task automatic runPass(int u, bit unl, logic [7:0] data, bit gaps, bit toggleMode);
    int n = lenOf(u);
    string req;
    req = !unl ? "R3" : ((n % 2) ? "R4" : "R5");
    doStart(u, unl);
    for (int k = 0; k < n; k++) begin
      if (gaps && (k % 2 == 1)) begin
        @(negedge clk);
        check(outV[u] == 1'b0, "R6 gap gives no output", outV[u], 0);
      end
      if (toggleMode) modeIn[u] = ~modeIn[u];
      inB[u] = data[k];
      inV[u] = 1'b1;
      @(negedge clk);
      inV[u] = 1'b0;
      check(outV[u] == 1'b1, "R6 output one clock later", outV[u], 1);
      check(outB[u] == (data[k] ^ flipAt(k + 1, unl, n)),
            toggleMode ? "R9 mode latched" : req,
            outB[u], data[k] ^ flipAt(k + 1, unl, n));
      check(doneW[u] == (k == n - 1), "R7 done timing", doneW[u], (k == n - 1));
    end
    modeIn[u] = unl;
  endtask

  task automatic overrun(int u);
    inV[u] = 1'b1;
    inB[u] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(outV[u] == 1'b0, "R7 input ignored after done", outV[u], 0);
      check(doneW[u] == 1'b1, "R7 done holds", doneW[u], 1);
    end
    inV[u] = 1'b0;
  endtask

  task automatic resetAndIdle();
    @(negedge clk);
    check(outV == 2'b00, "R1 outValid reset", outV, 0);
    check(doneW == 2'b00, "R1 done reset", doneW, 0);
    inV = 2'b11;
    inB = 2'b11;
    @(negedge clk);
    @(negedge clk);
    check(outV == 2'b00, "R1 no output before start", outV, 0);
    inV = 2'b00;
  endtask

  task automatic startCollision(int u);
    @(negedge clk);
    startP[u] = 1'b1;
    modeIn[u] = 1'b0;
    inV[u] = 1'b1;
    inB[u] = 1'b1;
    @(negedge clk);
    startP[u] = 1'b0;
    inV[u] = 1'b0;
    check(outV[u] == 1'b0, "R8 colliding bit discarded", outV[u], 0);
    // next bit must be treated as position 1 (load: inverted)
    inB[u] = 1'b0;
    inV[u] = 1'b1;
    @(negedge clk);
    inV[u] = 1'b0;
    check(outB[u] == 1'b1, "R8 position restarts at 1", outB[u], 1);
  endtask

  // captured responses pass an inverting chain model, then get corrected
  task automatic roundTrip(int u);
    int n = lenOf(u);
    logic [7:0] resp;
    logic [7:0] raw;
    resp = 8'($urandom);
    for (int i = 1; i <= n; i++) raw[i-1] = resp[i-1] ^ flipAt(i, 1'b1, n);
    doStart(u, 1'b1);
    for (int k = 0; k < n; k++) begin
      inB[u] = raw[k];
      inV[u] = 1'b1;
      @(negedge clk);
      inV[u] = 1'b0;
      check(outV[u] == 1'b1 && outB[u] == resp[k],
            (n % 2) ? "R4 round trip" : "R5 round trip", outB[u], resp[k]);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    resetAndIdle();
    runPass(0, 1'b0, 8'b1011_0010, 1'b0, 1'b0);
    overrun(0);
    runPass(1, 1'b0, 8'b0110_1101, 1'b1, 1'b0);
    overrun(1);
    runPass(0, 1'b1, 8'b0011_1001, 1'b1, 1'b0);
    runPass(1, 1'b1, 8'b1100_0111, 1'b0, 1'b0);
    runPass(0, 1'b1, 8'b0101_0101, 1'b0, 1'b1);
    runPass(1, 1'b0, 8'b1111_0000, 1'b0, 1'b1);
    startCollision(0);
    startCollision(1);
    for (int r = 0; r < 4; r++) begin
      roundTrip(0);
      roundTrip(1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule